// File: doc/BRIEF.md
# Bunch-Crossing Identifier Rebuilder

This block recovers the full 12-bit bunch-crossing number for a stream of aligned frame words arriving once per 25 ns crossing. Each word carries only the five least significant bits of the sender's crossing count, plus a marker bit that is high in exactly one crossing: the one directly after the sender's counter is cleared by a bunch-counter reset. The full count runs from 0 to 3563 and then wraps.

The rebuilder keeps its own modulo-3564 counter. A marked word loads that counter with a static start value (`sync_offset`, normally 0) and puts the block in the locked state. Every other valid word advances the counter by one. While locked, the low five bits of the rebuilt count are compared with the received five bits. A difference raises a one-cycle mismatch flag and bumps a saturating 16-bit error tally. Because 3564 is not a multiple of 32, the received field is checked against the full count taken modulo 32. It is never treated as a free-running 5-bit counter. All outputs are registered and change on the clock edge that accepts the word.

Top module: `bcid_rebuild`

## Requirements
- R1: After reset `bcid_full` is 0 and `bcid_valid`, `synced`, `mismatch` and `err_count` are all 0.
- R2: A valid word with `first_evt`=1 loads `bcid_full` with `sync_offset` (or with 0 if `sync_offset` is 3564 or more) and sets `synced` to 1, visible after the edge that accepts the word. `synced` then stays 1 until reset.
- R3: A valid word with `first_evt`=0 advances `bcid_full` by one, and `bcid_valid` is 1 in the following cycle.
- R4: A cycle with `word_valid`=0 leaves `bcid_full`, `err_count` and `synced` unchanged, and drives `bcid_valid` and `mismatch` to 0.
- R5: For every valid word accepted while locked, including the marked word itself, `mismatch` is 1 exactly when `bcid_low` differs from the new `bcid_full` modulo 32. Each mismatch adds one to `err_count`.
- R6: The count wraps from 3563 to 0, and the comparison follows that wrap. The word after count 3563 must carry 0 in its low field, not 12.
- R7: Before the first marked word, `synced` stays 0, `mismatch` stays 0 and `err_count` does not change, whatever `bcid_low` holds.
- R8: `err_count` saturates at 65535 and holds there on further mismatches.
- R9: A marked word received while already locked reloads the count from `sync_offset`, and is itself checked under R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| word_valid | input | 1 | An aligned frame word is present this cycle |
| first_evt | input | 1 | Marker: first crossing after the counter reset |
| bcid_low | input | 5 | Received low five bits of the crossing count |
| sync_offset | input | 12 | Count loaded on a marked word (static configuration) |
| bcid_full | output | 12 | Rebuilt crossing number, 0..3563 |
| bcid_valid | output | 1 | `bcid_full` belongs to a word accepted on the last edge |
| synced | output | 1 | At least one marked word has been seen since reset |
| mismatch | output | 1 | Last accepted word disagreed with the rebuilt count |
| err_count | output | 16 | Saturating tally of mismatches |

## Verification
The hardest states to reach from the ports are the wrap at 3563 and the saturated error tally. The wrap needs a full orbit of correctly numbered words after a marker, and saturation needs more than 65535 mismatches. The bench runs a 3563-word orbit whose low fields it computes itself, then checks that a 0 is accepted after the wrap and that the free-running value 12 would be flagged. It then runs one long burst of deliberately wrong fields to drive the tally into saturation and past it.

// File: rtl/bcid_pkg.sv
package bcid_pkg;
  typedef enum logic {
    LK_HUNT   = 1'b0,
    LK_LOCKED = 1'b1
  } lock_state_e;
endpackage

// File: rtl/bcid_counter.sv
module bcid_counter
  import bcid_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int PERIOD = 3564
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_en,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_d,
  output logic [CNT_W-1:0] cnt_q,
  output lock_state_e      lock_q
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  lock_state_e lock_d;
  logic [CNT_W-1:0] start_val;

  always_comb begin
    start_val = (load_val > LAST) ? '0 : load_val;
    cnt_d     = cnt_q;
    lock_d    = lock_q;
    if (load_en) begin
      cnt_d  = start_val;
      lock_d = LK_LOCKED;
    end else if (adv_en) begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lock_q <= LK_HUNT;
    end else if (adv_en || load_en) begin
      cnt_q  <= cnt_d;
      lock_q <= lock_d;
    end
  end

  assert_below_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  assert_lock_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q == LK_LOCKED |=> lock_q == LK_LOCKED);
endmodule

// File: rtl/bcid_check.sv
module bcid_check #(
  parameter int LOW_W = 5,
  parameter int ERR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chk_en,
  input  logic [LOW_W-1:0] exp_low,
  input  logic [LOW_W-1:0] rx_low,
  output logic             mis_q,
  output logic [ERR_W-1:0] err_q
);
  localparam logic [ERR_W-1:0] ERR_MAX = '1;
  localparam logic [ERR_W-1:0] ERR_ONE = ERR_W'(1);

  logic             mis_d;
  logic [ERR_W-1:0] err_d;

  always_comb begin
    mis_d = chk_en && (exp_low != rx_low);
    err_d = err_q;
    if (mis_d && (err_q != ERR_MAX)) err_d = err_q + ERR_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mis_q <= 1'b0;
      err_q <= '0;
    end else begin
      mis_q <= mis_d;
      if (mis_d) err_q <= err_d;
    end
  end

  assert_err_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (err_q == $past(err_q)) || (err_q == $past(err_q) + ERR_ONE));
  assert_err_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q == ERR_MAX |=> err_q == ERR_MAX);
  assert_err_follows_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q != $past(err_q)) |-> mis_q);
endmodule

// File: rtl/bcid_rebuild.sv
module bcid_rebuild
  import bcid_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int PERIOD = 3564,
  parameter int LOW_W  = 5,
  parameter int ERR_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             word_valid,
  input  logic             first_evt,
  input  logic [LOW_W-1:0] bcid_low,
  input  logic [CNT_W-1:0] sync_offset,
  output logic [CNT_W-1:0] bcid_full,
  output logic             bcid_valid,
  output logic             synced,
  output logic             mismatch,
  output logic [ERR_W-1:0] err_count
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic             load_en;
  logic             chk_en;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] cnt_q;
  lock_state_e      lock_q;
  logic             bval_q;

  assign load_en = word_valid && first_evt;
  assign chk_en  = word_valid && (load_en || (lock_q == LK_LOCKED));

  bcid_counter #(.CNT_W(CNT_W), .PERIOD(PERIOD)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv_en   (word_valid),
    .load_en  (load_en),
    .load_val (sync_offset),
    .cnt_d    (cnt_d),
    .cnt_q    (cnt_q),
    .lock_q   (lock_q)
  );

  bcid_check #(.LOW_W(LOW_W), .ERR_W(ERR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .chk_en  (chk_en),
    .exp_low (cnt_d[LOW_W-1:0]),
    .rx_low  (bcid_low),
    .mis_q   (mismatch),
    .err_q   (err_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bval_q <= 1'b0;
    else        bval_q <= word_valid;
  end

  assign bcid_full  = cnt_q;
  assign bcid_valid = bval_q;
  assign synced     = (lock_q == LK_LOCKED);

  assert_mis_needs_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |-> (synced && bcid_valid));
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |=> ($stable(bcid_full) && !mismatch && !bcid_valid));
  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !first_evt && bcid_full == LAST) |=> bcid_full == '0);
  assert_marker_locks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && first_evt) |=> synced);
endmodule

// File: tb/tb_bcid_rebuild.sv
module tb_bcid_rebuild;
  localparam int CLK_PERIOD = 25;
  localparam int NVEC = 9;

  typedef struct packed {
    logic        v;
    logic        f;
    logic [4:0]  lo;
    logic        e_bv;
    logic        e_sy;
    logic [11:0] e_full;
    logic        e_mis;
    logic [15:0] e_err;
  } vec_t;

  // offset 0 throughout the table
  localparam vec_t TBL [NVEC] = '{
    '{1'b1, 1'b0, 5'd7, 1'b1, 1'b0, 12'd1, 1'b0, 16'd0},  // R7 pre-lock, bad field ignored
    '{1'b1, 1'b1, 5'd0, 1'b1, 1'b1, 12'd0, 1'b0, 16'd0},  // R2 marker loads 0
    '{1'b1, 1'b0, 5'd1, 1'b1, 1'b1, 12'd1, 1'b0, 16'd0},  // R3 advance
    '{1'b0, 1'b0, 5'd9, 1'b0, 1'b1, 12'd1, 1'b0, 16'd0},  // R4 idle holds
    '{1'b1, 1'b0, 5'd2, 1'b1, 1'b1, 12'd2, 1'b0, 16'd0},  // R3
    '{1'b1, 1'b0, 5'd9, 1'b1, 1'b1, 12'd3, 1'b1, 16'd1},  // R5 mismatch
    '{1'b1, 1'b0, 5'd4, 1'b1, 1'b1, 12'd4, 1'b0, 16'd1},  // R5 back in step
    '{1'b1, 1'b1, 5'd5, 1'b1, 1'b1, 12'd0, 1'b1, 16'd2},  // R9 reload, checked
    '{1'b1, 1'b0, 5'd1, 1'b1, 1'b1, 12'd1, 1'b0, 16'd2}   // R9 continues from 0
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_valid = 1'b0;
  logic        first_evt = 1'b0;
  logic [4:0]  bcid_low = '0;
  logic [11:0] sync_offset = '0;
  logic [11:0] bcid_full;
  logic        bcid_valid;
  logic        synced;
  logic        mismatch;
  logic [15:0] err_count;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcid_rebuild dut (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .first_evt(first_evt),
    .bcid_low(bcid_low), .sync_offset(sync_offset), .bcid_full(bcid_full),
    .bcid_valid(bcid_valid), .synced(synced), .mismatch(mismatch),
    .err_count(err_count)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic f, input logic [4:0] lo);
    @(negedge clk);
    word_valid = v;
    first_evt  = f;
    bcid_low   = lo;
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    word_valid = 1'b0;
    first_evt = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int e;
    do_reset();
    @(posedge clk); #2;
    chk("R1 full",  32'(bcid_full), 0);
    chk("R1 valid", 32'(bcid_valid), 0);
    chk("R1 synced", 32'(synced), 0);
    chk("R1 mismatch", 32'(mismatch), 0);
    chk("R1 err", 32'(err_count), 0);

    for (int i = 0; i < NVEC; i++) begin
      step(TBL[i].v, TBL[i].f, TBL[i].lo);
      chk($sformatf("vec%0d bcid_valid", i), 32'(bcid_valid), 32'(TBL[i].e_bv));
      chk($sformatf("vec%0d synced", i),     32'(synced),     32'(TBL[i].e_sy));
      chk($sformatf("vec%0d full", i),       32'(bcid_full),  32'(TBL[i].e_full));
      chk($sformatf("vec%0d mismatch", i),   32'(mismatch),   32'(TBL[i].e_mis));
      chk($sformatf("vec%0d err", i),        32'(err_count),  32'(TBL[i].e_err));
    end

    // R6: full orbit with correct fields, then wrap
    step(1'b1, 1'b1, 5'd0);
    for (int k = 1; k <= 3563; k++) step(1'b1, 1'b0, 5'(k % 32));
    chk("R6 at 3563", 32'(bcid_full), 3563);
    chk("R6 no mismatch orbit", 32'(err_count), 2);
    step(1'b1, 1'b0, 5'd0);
    chk("R6 wrap to 0", 32'(bcid_full), 0);
    chk("R6 wrap field 0 accepted", 32'(mismatch), 0);
    // orbit again up to 3563, then offer the free-running value 12
    for (int k = 1; k <= 3563; k++) step(1'b1, 1'b0, 5'(k % 32));
    step(1'b1, 1'b0, 5'd12);
    chk("R6 field 12 after wrap flagged", 32'(mismatch), 1);
    chk("R6 err after wrap", 32'(err_count), 3);

    // R2: nonzero offset, and out-of-range offset
    sync_offset = 12'd100;
    step(1'b1, 1'b1, 5'd4);
    chk("R2 offset load", 32'(bcid_full), 100);
    chk("R2 offset field ok", 32'(mismatch), 0);
    step(1'b1, 1'b0, 5'd5);
    chk("R3 after offset", 32'(bcid_full), 101);
    sync_offset = 12'd4000;
    step(1'b1, 1'b1, 5'd0);
    chk("R2 out-of-range offset", 32'(bcid_full), 0);
    sync_offset = 12'd0;

    // R7 again after fresh reset: long bad run before the marker
    do_reset();
    for (int k = 0; k < 40; k++) step(1'b1, 1'b0, 5'd31);
    chk("R7 synced low", 32'(synced), 0);
    chk("R7 no errors counted", 32'(err_count), 0);
    chk("R7 mismatch low", 32'(mismatch), 0);

    // R8: saturation
    step(1'b1, 1'b1, 5'd0);
    e = 0;
    for (int k = 0; k < 65540; k++) begin
      e = (e == 3563) ? 0 : e + 1;
      step(1'b1, 1'b0, 5'((e + 1) % 32));
    end
    chk("R8 saturated", 32'(err_count), 65535);
    chk("R8 mismatch still flagged", 32'(mismatch), 1);
    chk("R8 count continues", 32'(bcid_full), 32'(e));
    step(1'b0, 1'b0, 5'd0);
    chk("R4 idle clears mismatch", 32'(mismatch), 0);
    chk("R4 idle holds err", 32'(err_count), 65535);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule